// File: doc/BRIEF.md
# Tunable Downconversion Mixer Front End

This block sits at the head of one receive channel. Each accepted real sample is taken from one of two 12-bit converter inputs and multiplied by the cosine and sine of a numerically controlled oscillator. The product is a complex baseband pair. The quadrature branch can be negated to mirror the spectrum. A programmable gain then scales both branches and clamps them to 16 bits. Any clamp raises a sticky flag. The decimating filters that follow, which reduce the rate by 120, are outside the block.

The oscillator is a 20-bit phase accumulator. It steps by the tuning word once per accepted sample. Its top six bits address a 64-point sine wave of amplitude 2047. That wave is built inside the block from a 17-entry quarter-wave table. Configuration is written through a small port with a 2-bit address and a 20-bit data word. The registers are: 0 for the tuning word, 1 for control (bit 0 selects source B, bit 1 enables inversion), 2 for the 8-bit gain, and 3 for clear (writing 1 to bit 0 clears the flag).

Top module: `ddc_mixer_stage`

## Requirements
- R1: With control bit 0 at 0 the mixer uses `adc_a`; with it at 1 it uses `adc_b`. Both inputs are two's complement.
- R2: The 20-bit phase starts at 0 after reset. Each sample is mixed with the phase held before that sample's own step. The phase advances by the tuning word, modulo 2^20, only on cycles where `ce` and `in_valid` are both high.
- R3: Take k = phase[19:14]. The sine value is round(2047·sin(2πk/64)) and the cosine value is round(2047·cos(2πk/64)).
- R4: The mixer forms I as x·cos and Q as −x·sin, where x is the selected sample.
- R5: With control bit 1 set, Q becomes +x·sin, so the spectrum is mirrored.
- R6: Each branch leaves as floor(p·g / 2048), where g is the unsigned gain register. The gain resets to 16 and is applied as results leave the pipeline.
- R7: A scaled value above 32767 is output as 32767. A value below −32768 is output as −32768. No value wraps.
- R8: `ovf_sticky` sets in the same cycle as an output that was clamped in either branch. It stays set until a write of 1 to bit 0 of register 3. A write of 0 leaves it alone. A clamp landing in the same cycle as a clear leaves the flag set.
- R9: `out_valid` pulses for one cycle, three enabled cycles after the sample was accepted. While `ce` is low the pipeline holds and no result is emitted.
- R10: Tuning and inversion writes apply to samples accepted after the write. `chan_rst` zeroes the phase and drops samples in flight. It leaves configuration and the flag untouched.
- R11: After reset `out_valid`, `out_i`, `out_q` and `ovf_sticky` are 0. The tuning word and control are 0, and the gain is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce | input | 1 | Clock enable for the sample pipeline |
| chan_rst | input | 1 | Synchronous channel reset of phase and pipeline |
| in_valid | input | 1 | A sample is present on the converter inputs |
| adc_a | input | 12 | Converter input A, signed |
| adc_b | input | 12 | Converter input B, signed |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 20 | Configuration write data |
| out_valid | output | 1 | One-cycle pulse per complex result |
| out_i | output | 16 | In-phase result, signed |
| out_q | output | 16 | Quadrature result, signed |
| ovf_sticky | output | 1 | Sticky clamp indicator |

## Verification
A clamped result can reach the output register on the same edge that a clear write lands on the flag. The bench provokes this with a full-scale sample at gain 255. It times a write of 1 to register 3 so that the write meets the sample's third pipeline edge, and it expects the flag to read 1 afterwards. A separate clear with no clamp in flight must then return the flag to 0.

// File: rtl/ddc_mix_pkg.sv
package ddc_mix_pkg;
  localparam int LUT_AW = 6;
  localparam int LUT_DW = 12;

  typedef enum logic [1:0] {
    REG_TUNE  = 2'd0,
    REG_CTRL  = 2'd1,
    REG_GAIN  = 2'd2,
    REG_CLEAR = 2'd3
  } cfg_reg_e;

  // first quadrant of a 2047-amplitude sine, 16 steps per quadrant
  function automatic logic [LUT_DW-1:0] quarter_sine(input logic [LUT_AW-2:0] k);
    logic [LUT_DW-1:0] v;
    case (k)
      5'd0:  v = 12'd0;
      5'd1:  v = 12'd201;
      5'd2:  v = 12'd399;
      5'd3:  v = 12'd594;
      5'd4:  v = 12'd783;
      5'd5:  v = 12'd965;
      5'd6:  v = 12'd1137;
      5'd7:  v = 12'd1299;
      5'd8:  v = 12'd1447;
      5'd9:  v = 12'd1582;
      5'd10: v = 12'd1702;
      5'd11: v = 12'd1805;
      5'd12: v = 12'd1891;
      5'd13: v = 12'd1959;
      5'd14: v = 12'd2008;
      5'd15: v = 12'd2037;
      default: v = 12'd2047;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/ddc_rst_sync.sv
module ddc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/ddc_sincos_lut.sv
module ddc_sincos_lut
  import ddc_mix_pkg::*;
(
  input  logic        [LUT_AW-1:0] idx_i,
  output logic signed [LUT_DW-1:0] sin_o,
  output logic signed [LUT_DW-1:0] cos_o
);
  localparam int QTR = 1 << (LUT_AW - 2);

  function automatic logic signed [LUT_DW-1:0] wave(input logic [LUT_AW-1:0] k);
    logic [LUT_AW-2:0] off;
    logic signed [LUT_DW-1:0] mag;
    if (k[LUT_AW-2]) off = (LUT_AW-1)'(QTR - int'(k[LUT_AW-3:0]));
    else             off = {1'b0, k[LUT_AW-3:0]};
    mag = $signed(quarter_sine(off));
    return k[LUT_AW-1] ? -mag : mag;
  endfunction

  always_comb begin
    sin_o = wave(idx_i);
    cos_o = wave(idx_i + LUT_AW'(QTR));
  end
endmodule

// File: rtl/ddc_nco.sv
module ddc_nco #(
  parameter int FCW_W = 20,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             adv_i,
  input  logic             clr_i,
  input  logic [FCW_W-1:0] fcw_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [FCW_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (clr_i)            acc_d = '0;
    else if (ce && adv_i) acc_d = acc_q + fcw_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign idx_o = acc_q[FCW_W-1 -: IDX_W];

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && ce && adv_i) |=> (acc_q == $past(acc_q) + $past(fcw_i))); // R2
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !(ce && adv_i)) |=> $stable(acc_q)); // R2
  AST_PHASE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0)); // R10
endmodule

// File: rtl/ddc_gain_sat.sv
module ddc_gain_sat #(
  parameter int PROD_W = 24,
  parameter int GAIN_W = 8,
  parameter int OUT_W  = 16,
  parameter int SHIFT  = 11
) (
  input  logic signed [PROD_W-1:0] prod_i,
  input  logic        [GAIN_W-1:0] gain_i,
  output logic signed [OUT_W-1:0]  y_o,
  output logic                     ovf_o
);
  localparam int WIDE_W = PROD_W + GAIN_W + 1;
  localparam logic signed [WIDE_W-1:0] MAXV = (WIDE_W'(1) <<< (OUT_W - 1)) - WIDE_W'(1);
  localparam logic signed [WIDE_W-1:0] MINV = -MAXV - WIDE_W'(1);

  logic signed [WIDE_W-1:0] p_ext, g_ext, wide, shifted;

  always_comb begin
    p_ext   = {{(GAIN_W+1){prod_i[PROD_W-1]}}, prod_i};
    g_ext   = $signed({{(PROD_W+1){1'b0}}, gain_i});
    wide    = p_ext * g_ext;
    shifted = wide >>> SHIFT;
    ovf_o   = 1'b0;
    if (shifted > MAXV) begin
      y_o   = MAXV[OUT_W-1:0];
      ovf_o = 1'b1;
    end else if (shifted < MINV) begin
      y_o   = MINV[OUT_W-1:0];
      ovf_o = 1'b1;
    end else begin
      y_o   = shifted[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/ddc_mixer_stage.sv
module ddc_mixer_stage
  import ddc_mix_pkg::*;
#(
  parameter int ADC_W      = 12,
  parameter int FCW_W      = 20,
  parameter int OUT_W      = 16,
  parameter int GAIN_W     = 8,
  parameter int GAIN_SHIFT = 11,
  parameter int GAIN_RESET = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  logic                    chan_rst,
  input  logic                    in_valid,
  input  logic        [ADC_W-1:0] adc_a,
  input  logic        [ADC_W-1:0] adc_b,
  input  logic                    cfg_we,
  input  logic        [1:0]       cfg_addr,
  input  logic        [FCW_W-1:0] cfg_wdata,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q,
  output logic                    ovf_sticky
);
  localparam int PROD_W = ADC_W + LUT_DW;
  localparam int LANES  = 2;

  logic rst_ns;
  ddc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  // configuration
  logic [FCW_W-1:0]  tune_q, tune_d;
  logic              sel_q, sel_d, inv_q, inv_d;
  logic [GAIN_W-1:0] gain_q, gain_d;
  logic              clear_hit;

  always_comb begin
    tune_d = tune_q;
    sel_d  = sel_q;
    inv_d  = inv_q;
    gain_d = gain_q;
    clear_hit = 1'b0;
    if (cfg_we) begin
      case (cfg_reg_e'(cfg_addr))
        REG_TUNE:  tune_d = cfg_wdata;
        REG_CTRL:  begin sel_d = cfg_wdata[0]; inv_d = cfg_wdata[1]; end
        REG_GAIN:  gain_d = cfg_wdata[GAIN_W-1:0];
        REG_CLEAR: clear_hit = cfg_wdata[0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      tune_q <= '0;
      sel_q  <= 1'b0;
      inv_q  <= 1'b0;
      gain_q <= GAIN_W'(GAIN_RESET);
    end else begin
      tune_q <= tune_d;
      sel_q  <= sel_d;
      inv_q  <= inv_d;
      gain_q <= gain_d;
    end
  end

  // oscillator
  logic [LUT_AW-1:0]        lut_idx;
  logic signed [LUT_DW-1:0] sin_w, cos_w;
  logic                     accept;

  assign accept = ce && in_valid && !chan_rst;

  ddc_nco #(.FCW_W(FCW_W), .IDX_W(LUT_AW)) u_nco (
    .clk(clk), .rst_n(rst_ns), .ce(ce), .adv_i(in_valid), .clr_i(chan_rst),
    .fcw_i(tune_q), .idx_o(lut_idx)
  );

  ddc_sincos_lut u_lut (.idx_i(lut_idx), .sin_o(sin_w), .cos_o(cos_w));

  // stage 1: capture sample and oscillator values
  logic                     v1_q, v1_d, inv1_q, inv1_d;
  logic signed [ADC_W-1:0]  x1_q, x1_d;
  logic signed [LUT_DW-1:0] c1_q, c1_d, s1_q, s1_d;
  // stage 2: products
  logic                     v2_q, v2_d;
  logic signed [PROD_W-1:0] p2_q [LANES];
  logic signed [PROD_W-1:0] p2_d [LANES];
  // stage 3: scaled outputs
  logic signed [OUT_W-1:0]  y_w   [LANES];
  logic                     ovf_w [LANES];
  logic                     vo_d, ovf_d;
  logic signed [OUT_W-1:0]  oi_d, oq_d;
  logic signed [PROD_W-1:0] mi, mq;

  always_comb begin
    v1_d = v1_q; inv1_d = inv1_q; x1_d = x1_q; c1_d = c1_q; s1_d = s1_q;
    v2_d = v2_q; p2_d = p2_q;
    vo_d = 1'b0; oi_d = out_i; oq_d = out_q;
    ovf_d = ovf_sticky;
    mi = x1_q * c1_q;
    mq = x1_q * s1_q;
    if (chan_rst) begin
      v1_d = 1'b0;
      v2_d = 1'b0;
    end else if (ce) begin
      v1_d = in_valid;
      v2_d = v1_q;
      vo_d = v2_q;
      if (accept) begin
        x1_d   = sel_q ? $signed(adc_b) : $signed(adc_a);
        c1_d   = cos_w;
        s1_d   = sin_w;
        inv1_d = inv_q;
      end
      if (v1_q) begin
        p2_d[0] = mi;
        p2_d[1] = inv1_q ? mq : -mq;
      end
      if (v2_q) begin
        oi_d = y_w[0];
        oq_d = y_w[1];
      end
    end
    if (clear_hit) ovf_d = 1'b0;
    if (ce && v2_q && !chan_rst && (ovf_w[0] || ovf_w[1])) ovf_d = 1'b1;
  end

  genvar ln;
  generate
    for (ln = 0; ln < LANES; ln++) begin : g_lane
      ddc_gain_sat #(.PROD_W(PROD_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W), .SHIFT(GAIN_SHIFT)) u_gain (
        .prod_i(p2_q[ln]), .gain_i(gain_q), .y_o(y_w[ln]), .ovf_o(ovf_w[ln])
      );
      always_ff @(posedge clk or negedge rst_ns) begin
        if (!rst_ns) p2_q[ln] <= '0;
        else         p2_q[ln] <= p2_d[ln];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      v1_q <= 1'b0; inv1_q <= 1'b0; x1_q <= '0; c1_q <= '0; s1_q <= '0;
      v2_q <= 1'b0;
      out_valid <= 1'b0; out_i <= '0; out_q <= '0; ovf_sticky <= 1'b0;
    end else begin
      v1_q <= v1_d; inv1_q <= inv1_d; x1_q <= x1_d; c1_q <= c1_d; s1_q <= s1_d;
      v2_q <= v2_d;
      out_valid <= vo_d; out_i <= oi_d; out_q <= oq_d; ovf_sticky <= ovf_d;
    end
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    (ovf_sticky && !clear_hit) |=> ovf_sticky); // R8
  AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(ovf_sticky) |-> out_valid); // R8
  AST_VALID_ON_CE: assert property (@(posedge clk) disable iff (!rst_ns)
    out_valid |-> $past(ce)); // R9
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_ns)
    chan_rst |=> !out_valid); // R10
endmodule

// File: tb/ddc_mixer_stage_tb_top.sv
`timescale 1ns/1ps
module ddc_mixer_stage_tb_top;
  logic clk = 1'b0;
  logic rst_n, ce, chan_rst, in_valid, cfg_we;
  logic [11:0] adc_a, adc_b;
  logic [1:0]  cfg_addr;
  logic [19:0] cfg_wdata;
  logic        out_valid, ovf_sticky;
  logic signed [15:0] out_i, out_q;

  always #2 clk = ~clk;

  ddc_mixer_stage dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .chan_rst(chan_rst), .in_valid(in_valid),
    .adc_a(adc_a), .adc_b(adc_b), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
    .ovf_sticky(ovf_sticky)
  );

  typedef struct { longint i; longint q; bit sat; } exp_t;
  exp_t eq[$];

  int checks = 0, fails = 0;
  int cyc = 0, last_out_cyc = 0, outs_seen = 0;
  int m_acc = 0, m_tune = 0, m_gain = 16;
  bit m_sel = 0, m_inv = 0, m_ovf = 0, pend_clr = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic int sinv(input int k);
    real a;
    a = 2047.0 * $sin(2.0 * 3.14159265358979 * real'(k) / 64.0);
    return (a >= 0.0) ? $rtoi(a + 0.5) : -$rtoi(-a + 0.5);
  endfunction

  function automatic longint scale(input longint p, input int g, output bit sat);
    longint y;
    y = (p * g) >>> 11;
    sat = 0;
    if (y > 32767) begin y = 32767; sat = 1; end
    else if (y < -32768) begin y = -32768; sat = 1; end
    return y;
  endfunction

  function automatic exp_t calc(input logic [11:0] raw);
    exp_t e;
    int k;
    longint x, pi, pq;
    bit si, sq;
    x = longint'($signed(raw));
    k = (m_acc >> 14) & 63;
    pi = x * sinv((k + 16) % 64);
    pq = x * sinv(k);
    if (!m_inv) pq = -pq;
    e.i = scale(pi, m_gain, si);
    e.q = scale(pq, m_gain, sq);
    e.sat = si | sq;
    return e;
  endfunction

  task automatic observe();
    exp_t e;
    cyc++;
    if (pend_clr) begin m_ovf = 0; pend_clr = 0; end
    if (out_valid) begin
      last_out_cyc = cyc;
      outs_seen++;
      if (eq.size() == 0) chk(0, "R9 unexpected out_valid", 1, 0);
      else begin
        e = eq.pop_front();
        chk(longint'(out_i) == e.i, "R1 R2 R3 R4 R6 R7 out_i", longint'(out_i), e.i);
        chk(longint'(out_q) == e.q, "R1 R2 R3 R5 R6 R7 out_q", longint'(out_q), e.q);
        if (e.sat) m_ovf = 1;
      end
    end
    chk(ovf_sticky == m_ovf, "R8 ovf_sticky", ovf_sticky, m_ovf);
  endtask

  task automatic step(input bit c, input bit v, input bit crst, input bit we,
                      input logic [1:0] ad, input logic [19:0] wd,
                      input logic [11:0] a, input logic [11:0] b);
    ce = c; in_valid = v; chan_rst = crst; cfg_we = we; cfg_addr = ad; cfg_wdata = wd;
    adc_a = a; adc_b = b;
    if (crst) begin m_acc = 0; eq.delete(); end
    else if (c && v) begin
      eq.push_back(calc(m_sel ? b : a));
      m_acc = (m_acc + m_tune) & 20'hFFFFF;
    end
    if (we) begin
      case (ad)
        2'd0: m_tune = int'(wd);
        2'd1: begin m_sel = wd[0]; m_inv = wd[1]; end
        2'd2: m_gain = int'(wd[7:0]);
        default: if (wd[0]) pend_clr = 1;
      endcase
    end
    @(negedge clk);
    observe();
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) step(1, 0, 0, 0, 2'd0, 20'd0, 12'd0, 12'd0);
  endtask

  task automatic wr(input logic [1:0] ad, input logic [19:0] wd);
    step(1, 0, 0, 1, ad, wd, 12'd0, 12'd0);
  endtask

  task automatic stream(input int n, input int ce_pct, input bit big);
    logic [11:0] a, b;
    for (int j = 0; j < n; j++) begin
      a = 12'($urandom); b = 12'($urandom);
      if (big && ($urandom_range(0, 3) == 0)) begin a = 12'h7FF; b = 12'h800; end
      step($urandom_range(0, 99) < ce_pct, $urandom_range(0, 9) < 7, 0, 0, 2'd0, 20'd0, a, b);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 0);
    report();
  end

  initial begin
    int seen;
    int start;
    logic [19:0] words [5];
    void'($urandom(32'd4711));
    words[0] = 20'h00000; words[1] = 20'h04000; words[2] = 20'h40000;
    words[3] = 20'hFFFFF; words[4] = 20'h12345;
    rst_n = 0; ce = 0; chan_rst = 0; in_valid = 0; cfg_we = 0;
    cfg_addr = 0; cfg_wdata = 0; adc_a = 0; adc_b = 0;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(out_valid == 0, "R11 out_valid", out_valid, 0);
    chk(out_i == 0, "R11 out_i", out_i, 0);
    chk(out_q == 0, "R11 out_q", out_q, 0);
    chk(ovf_sticky == 0, "R11 ovf_sticky", ovf_sticky, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R9 latency with defaults (R11 gain 16, phase 0)
    start = cyc;
    step(1, 1, 0, 0, 2'd0, 20'd0, 12'd1000, 12'd0);
    idle(4);
    chk(last_out_cyc - start == 3, "R9 latency", last_out_cyc - start, 3);

    // R9 hold while ce low
    step(1, 1, 0, 0, 2'd0, 20'd0, 12'h9AB, 12'd0);
    seen = outs_seen;
    for (int j = 0; j < 5; j++) step(0, 1, 0, 0, 2'd0, 20'd0, 12'h123, 12'd0);
    chk(outs_seen == seen, "R9 no output while ce low", outs_seen - seen, 0);
    idle(4);
    chk(outs_seen == seen + 1, "R9 output after ce returns", outs_seen - seen, 1);

    // R1 R2 R3 R4 R5: several tuning words, inversion off and on
    for (int w = 0; w < 5; w++) begin
      for (int inv = 0; inv < 2; inv++) begin
        wr(2'd0, words[w]);
        wr(2'd1, {18'd0, 1'(inv), 1'(w & 1)});
        stream(60, 90, 0);
        idle(5);
      end
    end

    // R10 tuning and inversion changed between consecutive samples
    for (int j = 0; j < 40; j++) begin
      step(1, 1, 0, 0, 2'd0, 20'd0, 12'($urandom), 12'($urandom));
      if (j % 5 == 0) wr(2'd0, 20'($urandom));
      if (j % 7 == 0) wr(2'd1, {18'd0, 1'($urandom), 1'($urandom)});
    end
    idle(5);

    // R8 clamp and clear land on the same edge: set wins
    wr(2'd1, 20'd0); wr(2'd0, 20'd0); wr(2'd2, 20'd255);
    step(1, 0, 1, 0, 2'd0, 20'd0, 12'd0, 12'd0);
    step(1, 1, 0, 0, 2'd0, 20'd0, 12'h7FF, 12'd0);
    idle(1);
    wr(2'd3, 20'd1);
    chk(ovf_sticky == 1, "R8 set wins over clear", ovf_sticky, 1);
    chk(out_i == 16'sh7FFF, "R7 positive clamp", out_i, 32767);
    wr(2'd3, 20'd0);
    chk(ovf_sticky == 1, "R8 write of 0 ignored", ovf_sticky, 1);
    wr(2'd3, 20'd1);
    chk(ovf_sticky == 0, "R8 clear", ovf_sticky, 0);
    // R7 negative clamp
    step(1, 1, 0, 0, 2'd0, 20'd0, 12'h800, 12'd0);
    idle(3);
    chk(ovf_sticky == 1, "R7 R8 negative clamp flag", ovf_sticky, 1);
    wr(2'd3, 20'd1);

    // R10 channel reset drops in-flight samples and zeroes phase
    wr(2'd2, 20'd16); wr(2'd0, 20'h2A000);
    step(1, 1, 0, 0, 2'd0, 20'd0, 12'd300, 12'd0);
    step(1, 1, 0, 0, 2'd0, 20'd0, 12'd400, 12'd0);
    seen = outs_seen;
    step(1, 0, 1, 0, 2'd0, 20'd0, 12'd0, 12'd0);
    idle(4);
    chk(outs_seen == seen, "R10 flushed samples", outs_seen - seen, 0);
    step(1, 1, 0, 0, 2'd0, 20'd0, 12'd500, 12'd0);
    idle(4);

    // constrained random phases (R6 R7 R8)
    for (int p = 0; p < 15; p++) begin
      wr(2'd0, 20'($urandom));
      wr(2'd1, {18'd0, 1'($urandom), 1'($urandom)});
      wr(2'd2, (p % 4 == 0) ? 20'd255 : 20'($urandom_range(0, 40)));
      stream(150, 80, p % 3 == 0);
      idle(5);
      if (p % 2 == 0) wr(2'd3, 20'd1);
    end
    idle(5);
    chk(eq.size() == 0, "R9 all results delivered", eq.size(), 0);
    report();
  end
endmodule